// File: doc/BRIEF.md
# Multi-Rate Search and Lock Controller

This controller chooses which serial data rate a clock-recovery loop should aim for and judges when that rate has locked. It samples a tick from the recovered clock after a fixed prescaler. The tick is a single-cycle strobe in the reference-clock domain, and the reference runs at 14.140 MHz. The controller counts these ticks over measurement windows of `WIN` reference cycles and compares each count with an expected count for the candidate rate. A count within 1% of the expected value declares lock. Once locked, only a count more than 2% away releases lock.

In automatic mode the controller walks a fixed list of candidate rates. It stays on each candidate for `DWELL` windows and moves on if no lock is found. The rate code output then reports the rate currently or most recently locked. In manual mode the controller aims only at the code on the select input, and the rate port direction flag tells the board that the code pins are driven from outside. A guard input removes the 177 Mb/s candidate, because byte-stuffed idle streams can false-lock there. A parameter removes the high-definition rate for the standard-definition-only build.

The outputs are the rate code, a locked flag, a standard/high-definition flag and the divide ratio the loop should use for the current candidate.

Top module: `rate_lock_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `locked_o`=0, `sd_o`=0, `rate_code_o`=000, `div_ratio_o`=16 and `rate_oe_o`=1.
- R2: Codes and divide ratios are 000=143 Mb/s (÷16), 001=177 (÷12), 010=270 (÷8), 011=360 (÷6), 100=540 (÷4) and 101=1485/1483.5 (÷2). Codes 110 and 111 give ÷16. `div_ratio_o` follows the candidate one cycle after the candidate is chosen.
- R3: A window spans `WIN` cycles of `clk`. The measured count is the number of cycles with `tick_i` high in that window. The expected count is floor(`WIN`×rate/1485).
- R4: When unlocked, lock is declared one cycle after the window result when |count−expected| ≤ expected/100 (integer division).
- R5: When locked, lock is released only when |count−expected| > expected/50. Counts between the two limits keep the current state.
- R6: In automatic mode the candidates run 000, 001, 010, 011, 100, then 101 (only when `HD_EN`=1), then back to 000. Each candidate is held for `DWELL` windows. A release of lock restarts the search at 000.
- R7: When `no177_i` is high, code 001 is skipped in the search and is never locked in either mode.
- R8: `rate_code_o` changes only when lock is declared, and it then shows the locked code. It holds that code through loss of lock.
- R9: `sd_o` is high only when locked to a code other than 101. It is low when unlocked or when locked to 101.
- R10: In manual mode only `rate_sel_i` is aimed at. Codes 110 and 111, and code 101 when `HD_EN`=0, never lock.
- R11: A change of `auto_i`, or of `rate_sel_i` in manual mode, clears `locked_o` at the next edge and starts a fresh measurement window. The candidate becomes `rate_sel_i` in manual mode and 000 in automatic mode.
- R12: `rate_oe_o` equals `auto_i` delayed by one cycle (high: the code pins are outputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (14.140 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| auto_i | input | 1 | 1 = automatic search, 0 = manual code |
| rate_sel_i | input | 3 | Manual rate code |
| no177_i | input | 1 | Removes the 177 Mb/s candidate |
| tick_i | input | 1 | Prescaled recovered-clock strobe, synchronous to clk |
| rate_code_o | output | 3 | Rate most recently locked |
| rate_oe_o | output | 1 | Code pins act as outputs (automatic mode) |
| locked_o | output | 1 | Frequency lock flag |
| sd_o | output | 1 | Locked to a standard-definition rate |
| div_ratio_o | output | 5 | Divide ratio for the current candidate |

## Verification
A window verdict and a mode or manual-code change can land on the same edge. In that case the change must win: lock clears and the pending verdict is dropped. The bench provokes this by switching `rate_sel_i` and `auto_i` while windows are closing throughout a long run. A cycle-accurate behavioural model replays both events in that priority and compares every output on every clock. Two more cases are driven at exact tick counts: the lock limit and the release limit falling on the same candidate's window boundary, checked at 720/719 and 713/712 ticks for the 540 Mb/s candidate.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int unsigned DIV_W   = 5;
  localparam int unsigned HD_MBPS = 1485;
  localparam logic [2:0]  CODE_177 = 3'd1;
  localparam logic [2:0]  CODE_540 = 3'd4;
  localparam logic [2:0]  CODE_HD  = 3'd5;

  function automatic logic [31:0] rate_mbps(input logic [2:0] c);
    case (c)
      3'd0:    return 32'd143;
      3'd1:    return 32'd177;
      3'd2:    return 32'd270;
      3'd3:    return 32'd360;
      3'd4:    return 32'd540;
      default: return 32'd1485;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] div_ratio(input logic [2:0] c);
    case (c)
      3'd0:    return DIV_W'(16);
      3'd1:    return DIV_W'(12);
      3'd2:    return DIV_W'(8);
      3'd3:    return DIV_W'(6);
      3'd4:    return DIV_W'(4);
      3'd5:    return DIV_W'(2);
      default: return DIV_W'(16);
    endcase
  endfunction

  function automatic logic [31:0] expected_count(input logic [2:0] c, input int unsigned win);
    logic [63:0] prod;
    prod = 64'(win) * 64'(rate_mbps(c));
    return 32'(prod / 64'(HD_MBPS));
  endfunction
endpackage

// File: rtl/rlc_window_meter.sv
module rlc_window_meter #(
  parameter int unsigned WIN = 8192,
  localparam int unsigned WC_W  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int unsigned CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             tick_i,
  output logic             done_o,
  output logic [CNT_W-1:0] meas_o
);
  logic [WC_W-1:0]  pos_q;
  logic [CNT_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      pos_q  <= '0;
      acc_q  <= '0;
      done_o <= 1'b0;
      if (rst) meas_o <= '0;
    end else if (pos_q == WC_W'(WIN - 1)) begin
      pos_q  <= '0;
      acc_q  <= '0;
      done_o <= 1'b1;
      meas_o <= acc_q + CNT_W'(tick_i);
    end else begin
      pos_q  <= pos_q + 1'b1;
      acc_q  <= acc_q + CNT_W'(tick_i);
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rlc_band_judge.sv
module rlc_band_judge
  import rlc_pkg::*;
#(
  parameter int unsigned WIN   = 8192,
  parameter bit          HD_EN = 1'b1,
  localparam int unsigned CNT_W = $clog2(WIN + 1)
) (
  input  logic [2:0]       cand_i,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             no177_i,
  output logic             in_lock_o,
  output logic             out_hold_o
);
  logic [31:0] exp_cnt, diff, meas_w;
  logic        cand_ok;

  always_comb begin
    exp_cnt = expected_count(cand_i, WIN);
    meas_w  = 32'(meas_i);
    diff    = (meas_w >= exp_cnt) ? (meas_w - exp_cnt) : (exp_cnt - meas_w);
    cand_ok = ((cand_i <= CODE_540) || ((cand_i == CODE_HD) && HD_EN))
              && !((cand_i == CODE_177) && no177_i);
    in_lock_o  = cand_ok && (diff <= exp_cnt / 32'd100);
    out_hold_o = !cand_ok || (diff > exp_cnt / 32'd50);
  end
endmodule

// File: rtl/rlc_sequencer.sv
module rlc_sequencer
  import rlc_pkg::*;
#(
  parameter int unsigned DWELL = 1,
  parameter bit          HD_EN = 1'b1,
  localparam int unsigned DW_W = (DWELL > 1) ? $clog2(DWELL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_i,
  input  logic [2:0]       sel_i,
  input  logic             no177_i,
  input  logic             done_i,
  input  logic             in_lock_i,
  input  logic             out_hold_i,
  output logic             restart_o,
  output logic [2:0]       cand_o,
  output logic             locked_o,
  output logic [2:0]       code_o,
  output logic             sd_o,
  output logic [DIV_W-1:0] div_o,
  output logic             oe_o
);
  logic            prev_auto_q;
  logic [2:0]      prev_sel_q;
  logic [2:0]      cand_d, code_d;
  logic            lk_d;
  logic [DW_W-1:0] dw_q, dw_d;

  function automatic logic [2:0] next_cand(input logic [2:0] c, input logic skip);
    case (c)
      3'd0:    return skip ? 3'd2 : 3'd1;
      3'd1:    return 3'd2;
      3'd2:    return 3'd3;
      3'd3:    return 3'd4;
      3'd4:    return HD_EN ? 3'd5 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  always_comb begin
    restart_o = (auto_i != prev_auto_q) || (!auto_i && (sel_i != prev_sel_q));
    cand_d = cand_o;
    code_d = code_o;
    lk_d   = locked_o;
    dw_d   = dw_q;
    if (restart_o) begin
      lk_d   = 1'b0;
      cand_d = auto_i ? 3'd0 : sel_i;
      dw_d   = '0;
    end else if (done_i) begin
      if (locked_o) begin
        if (out_hold_i) begin
          lk_d = 1'b0;
          dw_d = '0;
          if (auto_i) cand_d = 3'd0;
        end
      end else if (in_lock_i) begin
        lk_d   = 1'b1;
        code_d = cand_o;
        dw_d   = '0;
      end else if (dw_q == DW_W'(DWELL - 1)) begin
        dw_d = '0;
        if (auto_i) cand_d = next_cand(cand_o, no177_i);
      end else begin
        dw_d = dw_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_auto_q <= 1'b1;
      prev_sel_q  <= 3'd0;
      cand_o      <= 3'd0;
      code_o      <= 3'd0;
      locked_o    <= 1'b0;
      dw_q        <= '0;
      sd_o        <= 1'b0;
      div_o       <= div_ratio(3'd0);
      oe_o        <= 1'b1;
    end else begin
      prev_auto_q <= auto_i;
      prev_sel_q  <= sel_i;
      cand_o      <= cand_d;
      code_o      <= code_d;
      locked_o    <= lk_d;
      dw_q        <= dw_d;
      sd_o        <= lk_d && (code_d != CODE_HD);
      div_o       <= div_ratio(cand_d);
      oe_o        <= auto_i;
    end
  end
endmodule

// File: rtl/rate_lock_ctrl.sv
module rate_lock_ctrl
  import rlc_pkg::*;
#(
  parameter int unsigned WIN   = 8192,
  parameter int unsigned DWELL = 1,
  parameter bit          HD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_i,
  input  logic [2:0]       rate_sel_i,
  input  logic             no177_i,
  input  logic             tick_i,
  output logic [2:0]       rate_code_o,
  output logic             rate_oe_o,
  output logic             locked_o,
  output logic             sd_o,
  output logic [DIV_W-1:0] div_ratio_o
);
  localparam int unsigned CNT_W = $clog2(WIN + 1);

  logic             restart, done, in_lock, out_hold;
  logic [CNT_W-1:0] meas;
  logic [2:0]       cand;

  rlc_window_meter #(.WIN(WIN)) u_meter (
    .clk(clk), .rst(rst), .restart_i(restart), .tick_i(tick_i),
    .done_o(done), .meas_o(meas)
  );

  rlc_band_judge #(.WIN(WIN), .HD_EN(HD_EN)) u_judge (
    .cand_i(cand), .meas_i(meas), .no177_i(no177_i),
    .in_lock_o(in_lock), .out_hold_o(out_hold)
  );

  rlc_sequencer #(.DWELL(DWELL), .HD_EN(HD_EN)) u_seq (
    .clk(clk), .rst(rst), .auto_i(auto_i), .sel_i(rate_sel_i), .no177_i(no177_i),
    .done_i(done), .in_lock_i(in_lock), .out_hold_i(out_hold),
    .restart_o(restart), .cand_o(cand), .locked_o(locked_o), .code_o(rate_code_o),
    .sd_o(sd_o), .div_o(div_ratio_o), .oe_o(rate_oe_o)
  );
endmodule

// File: rtl/rate_lock_ctrl_chk.sv
module rate_lock_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       auto_i,
  input logic [2:0] rate_sel_i,
  input logic       no177_i,
  input logic       tick_i,
  input logic [2:0] rate_code_o,
  input logic       rate_oe_o,
  input logic       locked_o,
  input logic       sd_o,
  input logic [4:0] div_ratio_o
);
  AST_SD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    sd_o |-> locked_o && (rate_code_o != 3'd5)); // R9

  AST_NO_SKIPPED_LOCK: assert property (@(posedge clk) disable iff (rst)
    ($rose(locked_o) && (rate_code_o == 3'd1)) |-> !$past(no177_i)); // R7

  AST_MODE_CHANGE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (auto_i != $past(auto_i))) |=> !locked_o); // R11

  AST_CODE_MOVES_ON_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(rate_code_o)) |-> locked_o && !$past(locked_o)); // R8

  AST_OE_TRACKS_MODE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rate_oe_o == $past(auto_i))); // R12

  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
    div_ratio_o inside {5'd16, 5'd12, 5'd8, 5'd6, 5'd4, 5'd2}); // R2

  logic unused_ok;
  assign unused_ok = ^{rate_sel_i, tick_i};
endmodule

bind rate_lock_ctrl rate_lock_ctrl_chk u_chk (.*);

// File: tb/tb_rate_lock_ctrl.sv
`timescale 1ns/1ps
module tb_rate_lock_ctrl;
  localparam int WIN   = 2000;
  localparam int DWELL = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       auto_i = 1'b1;
  logic [2:0] rate_sel_i = 3'd0;
  logic       no177_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] rate_code_o, code_sd;
  logic       rate_oe_o, locked_o, sd_o, oe_sd, lk_sd, sdf_sd;
  logic [4:0] div_ratio_o, div_sd;

  int checks = 0, failures = 0;
  int tick_num = 0, tick_acc = 0;
  bit done_run = 0;

  always #2.5 clk = ~clk;

  rate_lock_ctrl #(.WIN(WIN), .DWELL(DWELL), .HD_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .auto_i(auto_i), .rate_sel_i(rate_sel_i), .no177_i(no177_i),
    .tick_i(tick_i), .rate_code_o(rate_code_o), .rate_oe_o(rate_oe_o),
    .locked_o(locked_o), .sd_o(sd_o), .div_ratio_o(div_ratio_o));

  rate_lock_ctrl #(.WIN(WIN), .DWELL(DWELL), .HD_EN(1'b0)) dut_sd (
    .clk(clk), .rst(rst), .auto_i(auto_i), .rate_sel_i(rate_sel_i), .no177_i(no177_i),
    .tick_i(tick_i), .rate_code_o(code_sd), .rate_oe_o(oe_sd),
    .locked_o(lk_sd), .sd_o(sdf_sd), .div_ratio_o(div_sd));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rate_of(input int c);
    case (c)
      0: return 143; 1: return 177; 2: return 270;
      3: return 360; 4: return 540; default: return 1485;
    endcase
  endfunction
  function automatic int div_of(input int c);
    case (c)
      0: return 16; 1: return 12; 2: return 8;
      3: return 6; 4: return 4; 5: return 2; default: return 16;
    endcase
  endfunction

  // behavioural reference model
  int m_pos, m_acc, m_meas, m_cand, m_code, m_dwell, m_prev_sel, m_div;
  bit m_done, m_lk, m_prev_auto, m_sd, m_oe;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_acc = 0; m_done = 0; m_meas = 0; m_cand = 0; m_code = 0;
      m_dwell = 0; m_lk = 0; m_prev_auto = 1; m_prev_sel = 0; m_div = 16; m_sd = 0; m_oe = 1;
    end else begin
      bit chg;
      chg = (auto_i != m_prev_auto) || (!auto_i && int'(rate_sel_i) != m_prev_sel);
      if (chg) begin
        m_lk = 0; m_dwell = 0;
        m_cand = auto_i ? 0 : int'(rate_sel_i);
      end else if (m_done) begin
        int e, d; bit ok;
        e = WIN * rate_of(m_cand) / 1485;
        d = (m_meas > e) ? m_meas - e : e - m_meas;
        ok = (m_cand <= 5) && !(m_cand == 1 && no177_i);
        if (m_lk) begin
          if (!ok || d > e / 50) begin
            m_lk = 0; m_dwell = 0;
            if (auto_i) m_cand = 0;
          end
        end else if (ok && d <= e / 100) begin
          m_lk = 1; m_code = m_cand; m_dwell = 0;
        end else if (m_dwell == DWELL - 1) begin
          m_dwell = 0;
          if (auto_i) begin
            if (m_cand == 5) m_cand = 0;
            else begin
              m_cand = m_cand + 1;
              if (m_cand == 1 && no177_i) m_cand = 2;
            end
          end
        end else m_dwell++;
      end
      if (chg) begin
        m_pos = 0; m_acc = 0; m_done = 0;
      end else if (m_pos == WIN - 1) begin
        m_done = 1; m_meas = m_acc + int'(tick_i); m_pos = 0; m_acc = 0;
      end else begin
        m_done = 0; m_pos++; m_acc += int'(tick_i);
      end
      m_prev_auto = auto_i; m_prev_sel = int'(rate_sel_i);
      m_sd = m_lk && (m_code != 5);
      m_div = div_of(m_cand);
      m_oe = auto_i;
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done_run) begin
      check(locked_o == m_lk, "R4 R5 R6 R11 locked_o", int'(locked_o), int'(m_lk));
      check(int'(rate_code_o) == m_code, "R8 rate_code_o", int'(rate_code_o), m_code);
      check(sd_o == m_sd, "R9 sd_o", int'(sd_o), int'(m_sd));
      check(int'(div_ratio_o) == m_div, "R2 div_ratio_o", int'(div_ratio_o), m_div);
      check(rate_oe_o == m_oe, "R12 rate_oe_o", int'(rate_oe_o), int'(m_oe));
    end
  end

  // tick generator: tick_num ticks per WIN cycles (R3)
  always @(negedge clk) begin
    tick_acc += tick_num;
    if (tick_acc >= WIN) begin tick_i <= 1'b1; tick_acc -= WIN; end
    else tick_i <= 1'b0;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done_run && cyc < 195000) begin @(posedge clk); cyc++; end
    if (!done_run) begin
      check(0, "watchdog expired", cyc, 195000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    check(!locked_o && !sd_o && rate_code_o == 3'd0 && div_ratio_o == 5'd16 && rate_oe_o,
          "R1 reset state", int'(locked_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!locked_o && div_ratio_o == 5'd16 && rate_oe_o, "R1 after release", int'(div_ratio_o), 16);

    // R6/R3: automatic search finds 360
    tick_num = 484;
    wait_cyc(20000);
    check(locked_o && rate_code_o == 3'd3, "R6 auto lock 360", int'(rate_code_o), 3);
    check(sd_o && div_ratio_o == 5'd6, "R9 R2 sd and divider at 360", int'(div_ratio_o), 6);

    // loss of lock restarts search, then 1485
    tick_num = 2000;
    wait_cyc(30000);
    check(locked_o && rate_code_o == 3'd5, "R6 auto lock 1485", int'(rate_code_o), 5);
    check(!sd_o && div_ratio_o == 5'd2, "R9 hd clears sd", int'(sd_o), 0);

    // R5 hysteresis
    tick_num = 1970;
    wait_cyc(6000);
    check(locked_o, "R5 hold at 1.5 pct", int'(locked_o), 1);
    tick_num = 1950;
    wait_cyc(5000);
    check(!locked_o && rate_code_o == 3'd5, "R5 R8 release beyond 2 pct, code kept", int'(locked_o), 0);

    // R7 skip 177
    no177_i = 1'b1; tick_num = 238;
    wait_cyc(26000);
    check(!locked_o, "R7 177 skipped", int'(locked_o), 0);
    no177_i = 1'b0;
    wait_cyc(26000);
    check(locked_o && rate_code_o == 3'd1 && div_ratio_o == 5'd12, "R7 177 found when allowed",
          int'(rate_code_o), 1);

    // R10 manual mode
    auto_i = 1'b0; rate_sel_i = 3'd2; tick_num = 363;
    @(negedge clk);
    check(!locked_o, "R11 mode change drops lock", int'(locked_o), 0);
    wait_cyc(5000);
    check(locked_o && rate_code_o == 3'd2 && !rate_oe_o, "R10 manual lock 270", int'(rate_code_o), 2);

    rate_sel_i = 3'd4; tick_num = 719;
    @(negedge clk);
    check(!locked_o, "R11 code change drops lock", int'(locked_o), 0);
    wait_cyc(6000);
    check(!locked_o, "R4 719 outside lock band", int'(locked_o), 0);
    tick_num = 720;
    wait_cyc(5000);
    check(locked_o && rate_code_o == 3'd4, "R4 720 inside lock band", int'(locked_o), 1);
    tick_num = 713;
    wait_cyc(5000);
    check(locked_o, "R5 713 held", int'(locked_o), 1);
    tick_num = 712;
    wait_cyc(5000);
    check(!locked_o, "R5 712 released", int'(locked_o), 0);

    rate_sel_i = 3'd5; tick_num = 2000;
    wait_cyc(5000);
    check(locked_o && rate_code_o == 3'd5, "R10 manual 1485 full build", int'(rate_code_o), 5);
    check(!lk_sd, "R10 101 ignored on sd build", int'(lk_sd), 0);

    rate_sel_i = 3'd7;
    wait_cyc(5000);
    check(!locked_o && rate_code_o == 3'd5, "R10 code 111 never locks", int'(locked_o), 0);

    auto_i = 1'b1;
    @(negedge clk);
    check(rate_oe_o && !locked_o, "R12 back to auto", int'(rate_oe_o), 1);

    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule